// File: doc/BRIEF.md
# DMA Line Splitter

This block takes one DMA job at a time and breaks it into memory transactions that each fit within a single cache line. A job is given as a start byte address, a byte length and a direction (load or store). The block sends one line transaction at a time. Each transaction names a line address, a byte offset inside that line, a byte count and a direction. The block waits for that transaction's response before it builds the next one. When every byte has been answered, it reports the job's identifier and is ready for a new job.

Data moves through an internal staging buffer. The buffer holds one word per line and keeps the same byte positions the bytes have in memory. Request byte `i` therefore sits at buffer byte `(start address mod LINE_BYTES) + i`, and chunk `k` uses buffer word `k`. Before a store job, software fills the buffer through the byte-wide host port. After a load job, it reads the result back through the same port. The memory side sees a plain valid/ready transaction channel and a response strobe that carries a full line.

Top module: `dma_line_splitter`

## Requirements
- R1: `req_ready` is high exactly while no job is active. Only one job is ever active. A request offered while a job runs is held off (ready low) and is never taken.
- R2: Op code 2'b00 is load and 2'b01 is store. A request taken while idle with any other op code, or with a length above MAX_LEN, starts no job and uses no identifier. It raises `req_err` for one cycle, in the cycle after the request is taken.
- R3: The first chunk has line address `addr / LINE_BYTES` and offset `addr mod LINE_BYTES`. Its length is the request length when offset plus length is at most LINE_BYTES. Otherwise its length is LINE_BYTES minus the offset.
- R4: Each later chunk has a line address one greater than the chunk before it and offset 0. Its length is the smaller of the bytes still outstanding and LINE_BYTES.
- R5: A chunk stays valid, with all its fields unchanged, until `ck_ready` takes it. No further chunk appears until `rsp_valid` has answered the chunk that was taken.
- R6: The cycle after the response that completes the job, `done_valid` pulses for one cycle with the job's identifier, and `req_ready` is high again in that same cycle.
- R7: Accepted legal jobs receive identifiers 0, 1, 2, … in order of acceptance, wrapping at 2^ID_W.
- R8: A legal job of length 0 issues no chunk. It pulses `done_valid` with its identifier in the cycle after it is taken.
- R9: For a store chunk, `ck_wdata` lanes from offset to offset+length-1 hold buffer word `k` at the same lanes, where `k` is the chunk number counted from 0. All other lanes are zero.
- R10: For a load chunk, the response lanes from offset to offset+length-1 are written into buffer word `k` at the same lanes. Buffer bytes outside those lanes are left unchanged.
- R11: A host write stores `hb_wdata` at buffer byte `hb_addr`. A host read returns the byte at `hb_addr` on `hb_rdata` one cycle after the address is presented.
- R12: `ck_write` is 1 for every chunk of a store job and 0 for every chunk of a load job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Job request offered |
| req_ready | output | 1 | Block idle; request taken when valid |
| req_op | input | 2 | 00 load, 01 store, others illegal |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | clog2(MAX_LEN+1) | Byte length |
| req_err | output | 1 | One-cycle pulse: rejected request |
| ck_valid | output | 1 | Line transaction offered |
| ck_ready | input | 1 | Line transaction taken |
| ck_write | output | 1 | 1 store, 0 load |
| ck_line_addr | output | ADDR_W-log2(LINE_BYTES) | Line address |
| ck_offset | output | log2(LINE_BYTES) | Byte offset within line |
| ck_len | output | log2(LINE_BYTES)+1 | Byte count of transaction |
| ck_wdata | output | 8*LINE_BYTES | Store payload in line byte lanes |
| rsp_valid | input | 1 | Response to the outstanding transaction |
| rsp_rdata | input | 8*LINE_BYTES | Load data line |
| done_valid | output | 1 | One-cycle completion pulse |
| done_id | output | ID_W | Identifier of completed job |
| hb_we | input | 1 | Host buffer byte write |
| hb_addr | input | log2(WORDS*LINE_BYTES) | Host buffer byte address |
| hb_wdata | input | 8 | Host write byte |
| hb_rdata | output | 8 | Host read byte, one cycle latency |

## Verification
Directed jobs cover each way a job can be split. A zero-length job and rejected op codes and lengths show that nothing is issued in those cases. A job that starts aligned and fills exactly one line, and a mid-line job that ends exactly at the line boundary, show that the short-first-chunk rule does not fire when it should not. A mid-line job that crosses into a second line separates the first-chunk rule from the later-chunk rule. A 4096-byte unaligned job reaches the last buffer word. Seeded random loads and stores of 1 to 300 bytes at arbitrary addresses, with random ready and response delays, exercise offset arithmetic, payload lane masking, buffer placement with guard bytes, and identifier sequencing, all against a chunk sequence the bench derives on its own.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ISSUE,
    ST_WAIT
  } dls_state_e;

  localparam logic [1:0] OP_LOAD  = 2'b00;
  localparam logic [1:0] OP_STORE = 2'b01;
endpackage

// File: rtl/dls_chunk_calc.sv
// Computes one transaction's byte count and lane mask from its start offset
// and the bytes still outstanding. Shared by the first and later chunks.
module dls_chunk_calc #(
  parameter  int LINE_BYTES = 64,
  parameter  int LEN_W      = 13,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int CLEN_W     = OFF_W + 1,
  localparam int CMP_W      = (LEN_W > CLEN_W) ? LEN_W : CLEN_W
) (
  input  logic [OFF_W-1:0]      offset_i,
  input  logic [LEN_W-1:0]      remain_i,
  output logic [CLEN_W-1:0]     len_o,
  output logic [LINE_BYTES-1:0] mask_o
);
  logic [CLEN_W-1:0] room;
  logic [CLEN_W-1:0] end_pos;
  logic              fits;

  always_comb begin
    room    = CLEN_W'(LINE_BYTES) - CLEN_W'(offset_i);
    fits    = CMP_W'(remain_i) < CMP_W'(room);
    len_o   = fits ? CLEN_W'(remain_i) : room;
    end_pos = CLEN_W'(offset_i) + len_o;
  end

  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
    assign mask_o[g] = (CLEN_W'(g) >= CLEN_W'(offset_i)) && (CLEN_W'(g) < end_pos);
  end
endmodule

// File: rtl/dls_line_ram.sv
// Line-wide staging buffer with per-byte enables on two ports.
// Port A: transfer engine. Port B: host byte access (wins on collision).
module dls_line_ram #(
  parameter  int LINE_BYTES = 64,
  parameter  int WORDS      = 65,
  localparam int AW         = $clog2(WORDS),
  localparam int DW         = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic [AW-1:0]         a_addr,
  input  logic [LINE_BYTES-1:0] a_be,
  input  logic [DW-1:0]         a_wdata,
  output logic [DW-1:0]         a_q,
  input  logic [AW-1:0]         b_addr,
  input  logic [LINE_BYTES-1:0] b_be,
  input  logic [DW-1:0]         b_wdata,
  output logic [DW-1:0]         b_q
);
  logic [DW-1:0] mem [WORDS];
  logic          b_ok;

  assign b_ok = {1'b0, b_addr} < (AW+1)'(WORDS);

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINE_BYTES; i++) begin
      if (a_be[i]) mem[a_addr][i*8 +: 8] <= a_wdata[i*8 +: 8];
      if (b_be[i] && b_ok) mem[b_addr][i*8 +: 8] <= b_wdata[i*8 +: 8];
    end
    a_q <= mem[a_addr];
    b_q <= b_ok ? mem[b_addr] : '0;
  end
endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter
  import dls_pkg::*;
#(
  parameter  int LINE_BYTES = 64,
  parameter  int ADDR_W     = 32,
  parameter  int MAX_LEN    = 4096,
  parameter  int ID_W       = 8,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int CLEN_W     = OFF_W + 1,
  localparam int LEN_W      = $clog2(MAX_LEN + 1),
  localparam int LINE_W     = ADDR_W - OFF_W,
  localparam int DATA_W     = LINE_BYTES * 8,
  localparam int WORDS      = (MAX_LEN + LINE_BYTES - 1) / LINE_BYTES + 1,
  localparam int WIDX_W     = $clog2(WORDS),
  localparam int BUF_AW     = WIDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_err,
  output logic              ck_valid,
  input  logic              ck_ready,
  output logic              ck_write,
  output logic [LINE_W-1:0] ck_line_addr,
  output logic [OFF_W-1:0]  ck_offset,
  output logic [CLEN_W-1:0] ck_len,
  output logic [DATA_W-1:0] ck_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id,
  input  logic              hb_we,
  input  logic [BUF_AW-1:0] hb_addr,
  input  logic [7:0]        hb_wdata,
  output logic [7:0]        hb_rdata
);
  dls_state_e state;

  logic [LINE_W-1:0]     start_line;
  logic [OFF_W-1:0]      start_off;
  logic [LEN_W-1:0]      tot_len;
  logic [LEN_W-1:0]      issued;
  logic [LEN_W-1:0]      completed;
  logic [WIDX_W-1:0]     widx;
  logic                  first;
  logic                  is_write;
  logic [ID_W-1:0]       cur_id;
  logic [ID_W-1:0]       next_id;
  logic [LINE_BYTES-1:0] lane_mask;
  logic [OFF_W-1:0]      hb_lane_q;

  // chunk arithmetic
  logic [OFF_W-1:0]      off_sel;
  logic [LEN_W-1:0]      remain;
  logic [CLEN_W-1:0]     calc_len;
  logic [LINE_BYTES-1:0] calc_mask;

  assign off_sel = first ? start_off : '0;
  assign remain  = tot_len - completed;

  dls_chunk_calc #(
    .LINE_BYTES(LINE_BYTES),
    .LEN_W     (LEN_W)
  ) u_calc (
    .offset_i(off_sel),
    .remain_i(remain),
    .len_o   (calc_len),
    .mask_o  (calc_mask)
  );

  // staging buffer
  logic [DATA_W-1:0]     ram_qa;
  logic [DATA_W-1:0]     ram_qb;
  logic [LINE_BYTES-1:0] a_be;
  logic [LINE_BYTES-1:0] b_be;

  assign a_be = (state == ST_WAIT && rsp_valid && !is_write) ? lane_mask : '0;
  assign b_be = hb_we ? (LINE_BYTES'(1) << hb_addr[OFF_W-1:0]) : '0;

  dls_line_ram #(
    .LINE_BYTES(LINE_BYTES),
    .WORDS     (WORDS)
  ) u_ram (
    .clk    (clk),
    .a_addr (widx),
    .a_be   (a_be),
    .a_wdata(rsp_rdata),
    .a_q    (ram_qa),
    .b_addr (hb_addr[BUF_AW-1:OFF_W]),
    .b_be   (b_be),
    .b_wdata({LINE_BYTES{hb_wdata}}),
    .b_q    (ram_qb)
  );

  always_ff @(posedge clk) begin
    hb_lane_q <= hb_addr[OFF_W-1:0];
  end
  assign hb_rdata = ram_qb[hb_lane_q*8 +: 8];

  // store payload: buffer word masked to the chunk's lanes
  logic [DATA_W-1:0] byte_mask;
  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_bmask
    assign byte_mask[g*8 +: 8] = {8{lane_mask[g]}};
  end
  assign ck_wdata = ck_write ? (ram_qa & byte_mask) : '0;

  assign req_ready = (state == ST_IDLE);

  logic legal;
  assign legal = ((req_op == OP_LOAD) || (req_op == OP_STORE)) &&
                 (req_len <= LEN_W'(MAX_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      start_line   <= '0;
      start_off    <= '0;
      tot_len      <= '0;
      issued       <= '0;
      completed    <= '0;
      widx         <= '0;
      first        <= 1'b0;
      is_write     <= 1'b0;
      cur_id       <= '0;
      next_id      <= '0;
      lane_mask    <= '0;
      ck_valid     <= 1'b0;
      ck_write     <= 1'b0;
      ck_line_addr <= '0;
      ck_offset    <= '0;
      ck_len       <= '0;
      done_valid   <= 1'b0;
      done_id      <= '0;
      req_err      <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      req_err    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (!legal) begin
              req_err <= 1'b1;
            end else begin
              start_line <= req_addr[ADDR_W-1:OFF_W];
              start_off  <= req_addr[OFF_W-1:0];
              tot_len    <= req_len;
              is_write   <= (req_op == OP_STORE);
              cur_id     <= next_id;
              next_id    <= next_id + 1'b1;
              issued     <= '0;
              completed  <= '0;
              widx       <= '0;
              first      <= 1'b1;
              if (req_len == '0) begin
                done_valid <= 1'b1;
                done_id    <= next_id;
              end else begin
                state <= ST_FETCH;
              end
            end
          end
        end
        ST_FETCH: begin
          ck_valid     <= 1'b1;
          ck_write     <= is_write;
          ck_line_addr <= start_line + LINE_W'(widx);
          ck_offset    <= off_sel;
          ck_len       <= calc_len;
          lane_mask    <= calc_mask;
          state        <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (ck_ready) begin
            ck_valid <= 1'b0;
            issued   <= issued + LEN_W'(ck_len);
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            completed <= issued;
            if (issued == tot_len) begin
              done_valid <= 1'b1;
              done_id    <= cur_id;
              state      <= ST_IDLE;
            end else begin
              widx  <= widx + 1'b1;
              first <= 1'b0;
              state <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
  parameter  int LINE_BYTES = 64,
  parameter  int ADDR_W     = 32,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int CLEN_W     = OFF_W + 1,
  localparam int LINE_W     = ADDR_W - OFF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_err,
  input logic              ck_valid,
  input logic              ck_ready,
  input logic              ck_write,
  input logic [LINE_W-1:0] ck_line_addr,
  input logic [OFF_W-1:0]  ck_offset,
  input logic [CLEN_W-1:0] ck_len,
  input logic              rsp_valid,
  input logic              done_valid
);
  logic first_q;
  logic outst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b0;
      outst_q <= 1'b0;
    end else begin
      if (req_valid && req_ready) first_q <= 1'b1;
      else if (ck_valid && ck_ready) first_q <= 1'b0;
      if (ck_valid && ck_ready) outst_q <= 1'b1;
      else if (rsp_valid) outst_q <= 1'b0;
    end
  end

  assert_single_job_R1: assert property (@(posedge clk) disable iff (rst)
    ck_valid |-> !req_ready);

  assert_chunk_fits_R3: assert property (@(posedge clk) disable iff (rst)
    ck_valid |-> (ck_len != '0) &&
      ((CLEN_W+1)'(ck_offset) + (CLEN_W+1)'(ck_len) <= (CLEN_W+1)'(LINE_BYTES)));

  assert_later_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    (ck_valid && !first_q) |-> (ck_offset == '0));

  assert_hold_chunk_R5: assert property (@(posedge clk) disable iff (rst)
    (ck_valid && !ck_ready) |=> ck_valid && $stable(ck_line_addr) &&
      $stable(ck_offset) && $stable(ck_len) && $stable(ck_write));

  assert_wait_response_R5: assert property (@(posedge clk) disable iff (rst)
    ck_valid |-> !outst_q);

  assert_pulses_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ck_valid, done_valid, req_err}));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> req_ready);
endmodule

bind dma_line_splitter dls_checker #(
  .LINE_BYTES(LINE_BYTES),
  .ADDR_W    (ADDR_W)
) u_dls_checker (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_err     (req_err),
  .ck_valid    (ck_valid),
  .ck_ready    (ck_ready),
  .ck_write    (ck_write),
  .ck_line_addr(ck_line_addr),
  .ck_offset   (ck_offset),
  .ck_len      (ck_len),
  .rsp_valid   (rsp_valid),
  .done_valid  (done_valid)
);

// File: tb/dma_line_splitter_bench.sv
module dma_line_splitter_bench;
  localparam int L      = 64;
  localparam int AW     = 32;
  localparam int MAXL   = 4096;
  localparam int IDW    = 8;
  localparam int OFFW   = 6;
  localparam int CLENW  = 7;
  localparam int LENW   = 13;
  localparam int LINEW  = AW - OFFW;
  localparam int DW     = L * 8;
  localparam int WORDS  = MAXL / L + 1;
  localparam int BUFB   = WORDS * L;
  localparam int BAW    = 13;
  localparam int WD_CYC = 150000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [1:0]       req_op = '0;
  logic [AW-1:0]    req_addr = '0;
  logic [LENW-1:0]  req_len = '0;
  logic             req_err;
  logic             ck_valid;
  logic             ck_ready = 1'b0;
  logic             ck_write;
  logic [LINEW-1:0] ck_line_addr;
  logic [OFFW-1:0]  ck_offset;
  logic [CLENW-1:0] ck_len;
  logic [DW-1:0]    ck_wdata;
  logic             rsp_valid = 1'b0;
  logic [DW-1:0]    rsp_rdata = '0;
  logic             done_valid;
  logic [IDW-1:0]   done_id;
  logic             hb_we = 1'b0;
  logic [BAW-1:0]   hb_addr = '0;
  logic [7:0]       hb_wdata = '0;
  logic [7:0]       hb_rdata;

  int             n_checks = 0;
  int             n_fail = 0;
  logic [IDW-1:0] exp_id = '0;
  logic [7:0]     src [BUFB];

  always #2 clk = ~clk;

  dma_line_splitter u_dma_line_splitter (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .req_err(req_err),
    .ck_valid(ck_valid), .ck_ready(ck_ready), .ck_write(ck_write),
    .ck_line_addr(ck_line_addr), .ck_offset(ck_offset), .ck_len(ck_len),
    .ck_wdata(ck_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .done_valid(done_valid), .done_id(done_id),
    .hb_we(hb_we), .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ {a[3:0], a[7:4]} ^ a[31:24] ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic host_wr(input int a, input logic [7:0] d);
    hb_we = 1'b1; hb_addr = BAW'(a); hb_wdata = d;
    @(negedge clk);
    hb_we = 1'b0;
  endtask

  task automatic host_rd(input int a, output logic [7:0] d);
    hb_addr = BAW'(a);
    @(negedge clk);
    d = hb_rdata;
  endtask

  task automatic run_job(input logic [1:0] op, input logic [31:0] addr, input int len);
    bit          legal = (op < 2) && (len <= MAXL);
    bit          wr = (op == 2'b01);
    int          off = int'(addr % L);
    int          rem = len;
    int          k = 0;
    logic [31:0] a = addr;
    logic [7:0]  rd;
    int          mism;

    if (legal && wr)
      for (int i = 0; i < len; i++) begin
        src[off+i] = 8'($urandom);
        host_wr(off + i, src[off+i]);
      end
    if (legal && !wr && len > 0) begin
      if (off > 0) host_wr(off - 1, 8'hA5);
      if (off + len < BUFB) host_wr(off + len, 8'h5A);
    end

    chk(req_ready == 1'b1, "R1 ready while idle", 64'(req_ready), 1);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_len = LENW'(len);
    @(negedge clk);
    req_valid = 1'b0;

    if (!legal) begin
      chk(req_err == 1'b1, "R2 error pulse", 64'(req_err), 1);
      chk(done_valid == 1'b0, "R2 no completion", 64'(done_valid), 0);
      @(negedge clk);
      chk(req_err == 1'b0 && ck_valid == 1'b0, "R2 no chunk, pulse ends",
          64'({req_err, ck_valid}), 0);
      return;
    end
    if (len == 0) begin
      chk(done_valid == 1'b1, "R8 zero length done", 64'(done_valid), 1);
      chk(done_id == exp_id, "R7 zero length id", 64'(done_id), 64'(exp_id));
      @(negedge clk);
      chk(ck_valid == 1'b0 && done_valid == 1'b0, "R8 no chunk",
          64'({ck_valid, done_valid}), 0);
      exp_id++;
      return;
    end

    while (rem > 0) begin
      int           eoff = (k == 0) ? int'(a % L) : 0;
      int           ecl = (rem < L - eoff) ? rem : L - eoff;
      logic [LINEW-1:0] eline = a[AW-1:OFFW];
      int           guard = 0;
      int           d;
      logic [DW-1:0] line;

      while (!ck_valid && guard < 8) begin @(negedge clk); guard++; end
      chk(ck_valid == 1'b1, "R5 chunk appears", 64'(ck_valid), 1);
      if (k == 0) begin
        chk(ck_line_addr == eline, "R3 first line address", 64'(ck_line_addr), 64'(eline));
        chk(int'(ck_offset) == eoff, "R3 first offset", 64'(ck_offset), 64'(eoff));
        chk(int'(ck_len) == ecl, "R3 first length", 64'(ck_len), 64'(ecl));
      end else begin
        chk(ck_line_addr == eline, "R4 later line address", 64'(ck_line_addr), 64'(eline));
        chk(ck_offset == '0, "R4 later offset zero", 64'(ck_offset), 0);
        chk(int'(ck_len) == ecl, "R4 later length", 64'(ck_len), 64'(ecl));
      end
      chk(ck_write == wr, "R12 direction", 64'(ck_write), 64'(wr));
      mism = 0;
      for (int b = 0; b < L; b++) begin
        logic [7:0] e = (wr && b >= eoff && b < eoff + ecl) ? src[k*L+b] : 8'h00;
        if (ck_wdata[b*8 +: 8] != e) mism++;
      end
      chk(mism == 0, "R9 store payload lanes", 64'(mism), 0);

      if (k == 0) begin
        req_valid = 1'b1; req_op = 2'b00; req_addr = '0; req_len = LENW'(1);
        chk(req_ready == 1'b0, "R1 busy holds off request", 64'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(ck_valid == 1'b1, "R5 hold during busy probe", 64'(ck_valid), 1);
      end
      d = int'($urandom % 3);
      repeat (d) begin
        @(negedge clk);
        chk(ck_valid && ck_line_addr == eline && int'(ck_len) == ecl,
            "R5 held chunk stable", 64'(ck_len), 64'(ecl));
      end
      ck_ready = 1'b1;
      @(negedge clk);
      ck_ready = 1'b0;
      chk(ck_valid == 1'b0, "R5 chunk taken", 64'(ck_valid), 0);
      d = int'($urandom % 3);
      repeat (d) begin
        @(negedge clk);
        chk(ck_valid == 1'b0 && done_valid == 1'b0, "R5 waits for response",
            64'({ck_valid, done_valid}), 0);
      end

      for (int b = 0; b < L; b++)
        line[b*8 +: 8] = wr ? 8'($urandom) : mem_byte({eline, 6'(b)});
      rsp_rdata = line;
      rsp_valid = 1'b1;
      @(negedge clk);
      rsp_valid = 1'b0;
      rem -= ecl;
      a += 32'(ecl);
      k++;
      if (rem == 0) begin
        chk(done_valid == 1'b1, "R6 completion pulse", 64'(done_valid), 1);
        chk(done_id == exp_id, "R7 completion id", 64'(done_id), 64'(exp_id));
        chk(req_ready == 1'b1, "R6 idle at completion", 64'(req_ready), 1);
      end else begin
        chk(done_valid == 1'b0, "R6 no early completion", 64'(done_valid), 0);
      end
    end
    exp_id++;

    @(negedge clk);
    chk(done_valid == 1'b0, "R6 single-cycle pulse", 64'(done_valid), 0);

    if (!wr) begin
      mism = 0;
      for (int i = 0; i < len; i++) begin
        host_rd(off + i, rd);
        if (rd != mem_byte(addr + 32'(i))) mism++;
      end
      chk(mism == 0, "R10 R11 load data placed", 64'(mism), 0);
      if (off > 0) begin
        host_rd(off - 1, rd);
        chk(rd == 8'hA5, "R10 guard below untouched", 64'(rd), 64'hA5);
      end
      if (off + len < BUFB) begin
        host_rd(off + len, rd);
        chk(rd == 8'h5A, "R10 guard above untouched", 64'(rd), 64'h5A);
      end
    end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog: actual=%0d cycles expected<%0d", WD_CYC, WD_CYC);
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h1D5A_0C41));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(req_ready && !ck_valid && !done_valid && !req_err, "R1 reset state",
        64'({req_ready, ck_valid, done_valid, req_err}), 64'h8);

    host_wr(7, 8'hC3);
    host_rd(7, rd);
    chk(rd == 8'hC3, "R11 host byte round trip", 64'(rd), 64'hC3);

    run_job(2'b00, 32'h0000_0100, 0);
    run_job(2'b10, 32'h0000_0040, 8);
    run_job(2'b11, 32'h0000_0040, 8);
    run_job(2'b00, 32'h0000_0040, MAXL + 1);
    run_job(2'b00, 32'h0000_1000, 64);
    run_job(2'b01, 32'h0000_200A, 20);
    run_job(2'b01, 32'h0000_3020, 32);
    run_job(2'b00, 32'h0000_403C, 10);
    run_job(2'b01, 32'h0000_5000, 130);
    run_job(2'b00, 32'h0001_0005, MAXL);
    for (int j = 0; j < 20; j++)
      run_job(2'($urandom % 2), $urandom, 1 + int'($urandom % 300));
    run_job(2'b01, 32'hFFFF_FFF0, 40);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule